// File: doc/BRIEF.md
# Masked Configuration Register File

This block holds a 64-dword configuration space (256 bytes) for an attached function. A host reaches it through a single-cycle register port that carries a dword index, a byte offset inside that dword and an access size of one, two or four bytes. Every dword has a fixed per-bit writable mask. A host write changes only the bits that are both inside the addressed byte lanes and inside that mask, so identification fields, status bits and other read-only fields keep their value. Accesses with a misaligned size or offset, and accesses beyond the last dword, are dropped.

A second port, for logic inside the function, changes any bits chosen by a caller-supplied mask. It ignores the writable mask. When both ports hit the same dword in one cycle, the internal update is applied on top of the host result. A read-overlay input lets an attached capability supply chosen bits of one dword as the host reads it. A parameter picks between an endpoint layout and a bridge layout, and that choice sets the reset contents and the writable masks. Identification values are also parameters.

Top module: `cfg_space_regfile`

## Requirements
- R1: After reset every dword holds its image value. Dword 0 is {DEVICE_ID, VENDOR_ID}. Dword 2 is {CLASS_CODE, SUBCLASS, PROG_IF, REVISION} from bit 31 down. For the endpoint layout, dword 3 is 0 and dword 11 is {SUBSYS_ID, SUBSYS_VENDOR}. For the bridge layout, dword 3 is 0x0001_0000 and dwords 7, 8 and 9 are 0x0000_00F0, 0x0000_FFF0 and 0x0001_FFF1. All other dwords are 0.
- R2: An accepted host write sets dword = (old & ~m) | ((host_wdata << 8*host_off) & m). Here m is the lane mask ANDed with the dword's writable mask. host_size code 0 is one byte (lane mask 0xFF << 8*off), code 1 is two bytes (0xFFFF << 8*off) and code 2 is four bytes (all lanes).
- R3: A four-byte write with host_off not 0 is dropped. A two-byte write with host_off 1 or 3 is dropped. A one-byte write is accepted at any offset. host_size code 3 is always dropped. A dropped write leaves every dword unchanged.
- R4: Dwords 0 and 2 have a writable mask of 0. Writing 0x0DF0ADBA to dword 0 leaves 0x5678_1234 (with the default IDs). In both layouts, dword 1 has mask 0x0000_FFFF and dword 3 has mask 0x0000_00FF. In the endpoint layout, dword 15 has mask 0x0000_00FF and all other dwords have mask 0.
- R5: A host write whose index is 64 or above changes nothing. A host read there returns 0xFFFF_FFFF.
- R6: An internal update sets dword upd_idx = (old & ~upd_mask) | (upd_data & upd_mask), whatever the writable mask.
- R7: If a host write and an internal update hit the same dword in one cycle, the result is the host merge followed by the update merge.
- R8: If a host read hits the dword ovl_idx while ovl_en is 1, the data returned is (dword & ~ovl_mask) | (ovl_data & ovl_mask). Reads of other dwords are unaffected.
- R9: host_rdata takes the read value on the clock edge where host_rd_en is sampled, and holds it until the next read. A read in the same cycle as a write returns the contents from before the write.
- R10: In the bridge layout the writable masks are: dword 6 0x00FF_FFFF, dword 7 0xF900_0000, dwords 8 and 9 0xFFF0_FFF0, dwords 10 and 11 0xFFFF_FFFF, dword 15 0xFFFF_00FF. All other dwords not named in R4 have mask 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe |
| host_idx | input | 7 | Dword index; values 64 and above are out of range |
| host_off | input | 2 | Byte offset inside the dword |
| host_size | input | 2 | Access size code: 0 one byte, 1 two bytes, 2 four bytes, 3 invalid |
| host_wdata | input | 32 | Write data, right-aligned in the low lanes |
| host_rdata | output | 32 | Registered read data |
| upd_en | input | 1 | Internal update strobe |
| upd_idx | input | 6 | Internal update dword index |
| upd_mask | input | 32 | Bits changed by the internal update |
| upd_data | input | 32 | Internal update data |
| ovl_en | input | 1 | Read overlay active |
| ovl_idx | input | 6 | Dword covered by the overlay |
| ovl_mask | input | 32 | Bits supplied by the overlay |
| ovl_data | input | 32 | Overlay bit values |

## Verification
The bench builds two copies of the block side by side: one with the endpoint layout and one with the bridge layout. Both use the default identification values and 64 dwords, and both are driven by the same stimulus. This makes each layout's reset image and writable masks visible on the same accesses. Random writes, updates and reads cover index values up to 70, all offsets and all four size codes. This reaches the dropped and out-of-range cases along with the accepted merges. Directed sequences cover the same-cycle collision, the overlay, and the read-while-write and read-hold timing.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;

    localparam int DWORD_W  = 32;
    localparam int LANES    = DWORD_W / 8;
    localparam int OFF_W    = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic [15:0] vendor;
        logic [15:0] device;
        logic [7:0]  cls;
        logic [7:0]  sub;
        logic [7:0]  pif;
        logic [7:0]  rev;
        logic [15:0] ss_vendor;
        logic [15:0] ss_id;
    } cfg_ident_t;

    // Writable mask of one dword for the selected layout.
    function automatic logic [DWORD_W-1:0] hdr_wmask(input logic bridge, input int idx);
        logic [DWORD_W-1:0] m;
        m = '0;
        case (idx)
            1:  m = 32'h0000_FFFF;
            3:  m = 32'h0000_00FF;
            default: m = '0;
        endcase
        if (bridge) begin
            case (idx)
                6:  m = 32'h00FF_FFFF;
                7:  m = 32'hF900_0000;
                8:  m = 32'hFFF0_FFF0;
                9:  m = 32'hFFF0_FFF0;
                10: m = 32'hFFFF_FFFF;
                11: m = 32'hFFFF_FFFF;
                15: m = 32'hFFFF_00FF;
                default: ;
            endcase
        end else if (idx == 15) begin
            m = 32'h0000_00FF;
        end
        return m;
    endfunction

    // Reset content of one dword for the selected layout.
    function automatic logic [DWORD_W-1:0] hdr_init(input logic bridge, input int idx,
                                                    input cfg_ident_t id);
        logic [DWORD_W-1:0] v;
        v = '0;
        case (idx)
            0: v = {id.device, id.vendor};
            2: v = {id.cls, id.sub, id.pif, id.rev};
            default: v = '0;
        endcase
        if (bridge) begin
            case (idx)
                3: v = 32'h0001_0000;
                7: v = 32'h0000_00F0;
                8: v = 32'h0000_FFF0;
                9: v = 32'h0001_FFF1;
                default: ;
            endcase
        end else if (idx == 11) begin
            v = {id.ss_id, id.ss_vendor};
        end
        return v;
    endfunction

endpackage

// File: rtl/cfgs_reset_image.sv
module cfgs_reset_image
    import cfgs_pkg::*;
#(
    parameter int         NUM_REGS   = 64,
    parameter logic       HDR_BRIDGE = 1'b0,
    parameter cfg_ident_t IDENT      = '0
) (
    output logic [NUM_REGS-1:0][DWORD_W-1:0] init_img,
    output logic [NUM_REGS-1:0][DWORD_W-1:0] wmask_img
);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_dw
        assign init_img[i]  = hdr_init(HDR_BRIDGE, i, IDENT);
        assign wmask_img[i] = hdr_wmask(HDR_BRIDGE, i);
    end

endmodule

// File: rtl/cfgs_lane_merge.sv
module cfgs_lane_merge
    import cfgs_pkg::*;
(
    input  logic [OFF_W-1:0]   wr_off,
    input  logic [1:0]         wr_size,
    input  logic [DWORD_W-1:0] wr_data,
    output logic               accept,
    output logic [DWORD_W-1:0] lane_mask,
    output logic [DWORD_W-1:0] lane_data
);

    localparam int SH_W = OFF_W + 3;

    logic [SH_W-1:0] bit_shift;

    assign bit_shift = {wr_off, 3'b000};
    assign lane_data = wr_data << bit_shift;

    always_comb begin
        accept    = 1'b0;
        lane_mask = '0;
        case (acc_size_e'(wr_size))
            SZ_BYTE: begin
                accept    = 1'b1;
                lane_mask = DWORD_W'(8'hFF) << bit_shift;
            end
            SZ_HALF: begin
                accept    = (wr_off[0] == 1'b0);
                lane_mask = DWORD_W'(16'hFFFF) << bit_shift;
            end
            SZ_WORD: begin
                accept    = (wr_off == '0);
                lane_mask = '1;
            end
            default: begin
                accept    = 1'b0;
                lane_mask = '0;
            end
        endcase
    end

endmodule

// File: rtl/cfgs_read_mux.sv
module cfgs_read_mux
    import cfgs_pkg::*;
#(
    parameter int NUM_REGS = 64,
    localparam int AW      = $clog2(NUM_REGS),
    localparam int IDX_W   = AW + 1
) (
    input  logic [NUM_REGS-1:0][DWORD_W-1:0] regs,
    input  logic [IDX_W-1:0]                 rd_idx,
    input  logic                             ovl_en,
    input  logic [AW-1:0]                    ovl_idx,
    input  logic [DWORD_W-1:0]               ovl_mask,
    input  logic [DWORD_W-1:0]               ovl_data,
    output logic [DWORD_W-1:0]               rd_value
);

    logic               in_range;
    logic [AW-1:0]      rd_ix;
    logic               ovl_hit;
    logic [DWORD_W-1:0] raw;

    assign in_range = (rd_idx < IDX_W'(NUM_REGS));
    assign rd_ix    = rd_idx[AW-1:0];
    assign ovl_hit  = ovl_en && (ovl_idx == rd_ix);

    always_comb begin
        raw = regs[rd_ix];
        if (!in_range) begin
            rd_value = '1;
        end else if (ovl_hit) begin
            rd_value = (raw & ~ovl_mask) | (ovl_data & ovl_mask);
        end else begin
            rd_value = raw;
        end
    end

endmodule

// File: rtl/cfg_space_regfile.sv
module cfg_space_regfile
    import cfgs_pkg::*;
#(
    parameter int          NUM_REGS      = 64,
    parameter logic        HDR_BRIDGE    = 1'b0,
    parameter logic [15:0] VENDOR_ID     = 16'h1234,
    parameter logic [15:0] DEVICE_ID     = 16'h5678,
    parameter logic [7:0]  CLASS_CODE    = 8'h04,
    parameter logic [7:0]  SUBCLASS      = 8'h01,
    parameter logic [7:0]  PROG_IF       = 8'h00,
    parameter logic [7:0]  REVISION      = 8'h00,
    parameter logic [15:0] SUBSYS_VENDOR = 16'hABCD,
    parameter logic [15:0] SUBSYS_ID     = 16'h2468
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          host_wr_en,
    input  logic                          host_rd_en,
    input  logic [$clog2(NUM_REGS):0]     host_idx,
    input  logic [1:0]                    host_off,
    input  logic [1:0]                    host_size,
    input  logic [31:0]                   host_wdata,
    output logic [31:0]                   host_rdata,
    input  logic                          upd_en,
    input  logic [$clog2(NUM_REGS)-1:0]   upd_idx,
    input  logic [31:0]                   upd_mask,
    input  logic [31:0]                   upd_data,
    input  logic                          ovl_en,
    input  logic [$clog2(NUM_REGS)-1:0]   ovl_idx,
    input  logic [31:0]                   ovl_mask,
    input  logic [31:0]                   ovl_data
);

    localparam int AW    = $clog2(NUM_REGS);
    localparam int IDX_W = AW + 1;

    localparam cfg_ident_t IDENT = '{
        vendor:    VENDOR_ID,
        device:    DEVICE_ID,
        cls:       CLASS_CODE,
        sub:       SUBCLASS,
        pif:       PROG_IF,
        rev:       REVISION,
        ss_vendor: SUBSYS_VENDOR,
        ss_id:     SUBSYS_ID
    };

    typedef struct packed {
        logic [NUM_REGS-1:0][DWORD_W-1:0] regs;
        logic [DWORD_W-1:0]               rdata;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_REGS-1:0][DWORD_W-1:0] init_img;
    logic [NUM_REGS-1:0][DWORD_W-1:0] wmask_all;
    logic [NUM_REGS-1:0][DWORD_W-1:0] regs_q;

    logic               host_in_range;
    logic [AW-1:0]      host_ix;
    logic               lane_ok;
    logic [DWORD_W-1:0] lane_mask;
    logic [DWORD_W-1:0] lane_data;
    logic [DWORD_W-1:0] rd_value;
    logic               upd_in_range;

    assign host_in_range = (host_idx < IDX_W'(NUM_REGS));
    assign host_ix       = host_idx[AW-1:0];
    assign upd_in_range  = ({1'b0, upd_idx} < IDX_W'(NUM_REGS));
    assign regs_q        = state_q.regs;
    assign host_rdata    = state_q.rdata;

    cfgs_reset_image #(
        .NUM_REGS   (NUM_REGS),
        .HDR_BRIDGE (HDR_BRIDGE),
        .IDENT      (IDENT)
    ) u_img (
        .init_img   (init_img),
        .wmask_img  (wmask_all)
    );

    cfgs_lane_merge u_lane (
        .wr_off     (host_off),
        .wr_size    (host_size),
        .wr_data    (host_wdata),
        .accept     (lane_ok),
        .lane_mask  (lane_mask),
        .lane_data  (lane_data)
    );

    cfgs_read_mux #(
        .NUM_REGS   (NUM_REGS)
    ) u_rd (
        .regs       (state_q.regs),
        .rd_idx     (host_idx),
        .ovl_en     (ovl_en),
        .ovl_idx    (ovl_idx),
        .ovl_mask   (ovl_mask),
        .ovl_data   (ovl_data),
        .rd_value   (rd_value)
    );

    always_comb begin
        logic [DWORD_W-1:0] eff_mask;
        state_d  = state_q;
        eff_mask = lane_mask & wmask_all[host_ix];
        // host merge through lane and writable masks
        if (host_wr_en && host_in_range && lane_ok) begin
            state_d.regs[host_ix] = (state_q.regs[host_ix] & ~eff_mask)
                                  | (lane_data & eff_mask);
        end
        // internal update lands on top of any host merge
        if (upd_en && upd_in_range) begin
            state_d.regs[upd_idx] = (state_d.regs[upd_idx] & ~upd_mask)
                                  | (upd_data & upd_mask);
        end
        if (host_rd_en) begin
            state_d.rdata = rd_value;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.regs  <= init_img;
            state_q.rdata <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/cfgs_regfile_chk.sv
module cfgs_regfile_chk #(
    parameter int NUM_REGS = 64,
    localparam int AW      = $clog2(NUM_REGS),
    localparam int IDX_W   = AW + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       host_wr_en,
    input  logic                       host_rd_en,
    input  logic [IDX_W-1:0]           host_idx,
    input  logic [1:0]                 host_off,
    input  logic [1:0]                 host_size,
    input  logic [31:0]                host_rdata,
    input  logic                       upd_en,
    input  logic [AW-1:0]              upd_idx,
    input  logic [31:0]                upd_mask,
    input  logic [31:0]                upd_data,
    input  logic                       ovl_en,
    input  logic [AW-1:0]              ovl_idx,
    input  logic [31:0]                ovl_mask,
    input  logic [31:0]                ovl_data,
    input  logic [NUM_REGS-1:0][31:0]  regs_q,
    input  logic [NUM_REGS-1:0][31:0]  wmask_q
);

    logic          in_range;
    logic [AW-1:0] ix;
    logic          ro_pend_q;
    logic [AW-1:0] ro_ix_q;
    logic [31:0]   ro_bits_q;
    logic          up_pend_q;
    logic [AW-1:0] up_ix_q;
    logic [31:0]   up_mask_q;
    logic [31:0]   up_data_q;

    assign in_range = (host_idx < IDX_W'(NUM_REGS));
    assign ix       = host_idx[AW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ro_pend_q <= 1'b0;
            ro_ix_q   <= '0;
            ro_bits_q <= '0;
            up_pend_q <= 1'b0;
            up_ix_q   <= '0;
            up_mask_q <= '0;
            up_data_q <= '0;
        end else begin
            ro_pend_q <= host_wr_en && in_range && !upd_en;
            ro_ix_q   <= ix;
            ro_bits_q <= regs_q[ix] & ~wmask_q[ix];
            up_pend_q <= upd_en;
            up_ix_q   <= upd_idx;
            up_mask_q <= upd_mask;
            up_data_q <= upd_data;
        end
    end

    // R2 / R4: bits outside the writable mask survive a host write
    a_r2_ro_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ro_pend_q |-> ((regs_q[ro_ix_q] & ~wmask_q[ro_ix_q]) == ro_bits_q));

    // R3: a misaligned four-byte write leaves the whole space unchanged
    a_r3_misaligned_word: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && host_size == 2'd2 && host_off != 2'd0 && !upd_en) |=> $stable(regs_q));

    // R3: invalid size code changes nothing
    a_r3_bad_size: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && host_size == 2'd3 && !upd_en) |=> $stable(regs_q));

    // R4: identification dword only moves under an internal update
    a_r4_id_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_en && upd_idx == '0) |=> $stable(regs_q[0]));

    // R5: out-of-range read returns all ones
    a_r5_oob_read: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_en && !in_range) |=> (host_rdata == 32'hFFFF_FFFF));

    // R6 / R7: updated bits carry the update data, after any host write
    a_r6_update_bits: assert property (@(posedge clk) disable iff (!rst_n)
        up_pend_q |-> ((regs_q[up_ix_q] & up_mask_q) == (up_data_q & up_mask_q)));

    // R8: overlay bits appear in read data
    a_r8_overlay: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_en && in_range && ovl_en && ovl_idx == ix)
        |=> ((host_rdata & $past(ovl_mask)) == ($past(ovl_data) & $past(ovl_mask))));

    // R9: read data holds without a read strobe
    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd_en |=> $stable(host_rdata));

endmodule

bind cfg_space_regfile cfgs_regfile_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr_en (host_wr_en),
    .host_rd_en (host_rd_en),
    .host_idx   (host_idx),
    .host_off   (host_off),
    .host_size  (host_size),
    .host_rdata (host_rdata),
    .upd_en     (upd_en),
    .upd_idx    (upd_idx),
    .upd_mask   (upd_mask),
    .upd_data   (upd_data),
    .ovl_en     (ovl_en),
    .ovl_idx    (ovl_idx),
    .ovl_mask   (ovl_mask),
    .ovl_data   (ovl_data),
    .regs_q     (regs_q),
    .wmask_q    (wmask_all)
);

// File: tb/cfg_space_regfile_tb.sv
module cfg_space_regfile_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic        host_rd_en = 1'b0;
    logic [6:0]  host_idx = '0;
    logic [1:0]  host_off = '0;
    logic [1:0]  host_size = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] rdata_ep, rdata_br;
    logic        upd_en = 1'b0;
    logic [5:0]  upd_idx = '0;
    logic [31:0] upd_mask = '0;
    logic [31:0] upd_data = '0;
    logic        ovl_en = 1'b0;
    logic [5:0]  ovl_idx = '0;
    logic [31:0] ovl_mask = '0;
    logic [31:0] ovl_data = '0;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] ex [2][64];

    always #5 clk = ~clk;

    cfg_space_regfile #(.HDR_BRIDGE(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
        .host_idx(host_idx), .host_off(host_off), .host_size(host_size),
        .host_wdata(host_wdata), .host_rdata(rdata_ep), .upd_en(upd_en),
        .upd_idx(upd_idx), .upd_mask(upd_mask), .upd_data(upd_data),
        .ovl_en(ovl_en), .ovl_idx(ovl_idx), .ovl_mask(ovl_mask), .ovl_data(ovl_data));

    cfg_space_regfile #(.HDR_BRIDGE(1'b1)) u_dut_br (
        .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
        .host_idx(host_idx), .host_off(host_off), .host_size(host_size),
        .host_wdata(host_wdata), .host_rdata(rdata_br), .upd_en(upd_en),
        .upd_idx(upd_idx), .upd_mask(upd_mask), .upd_data(upd_data),
        .ovl_en(ovl_en), .ovl_idx(ovl_idx), .ovl_mask(ovl_mask), .ovl_data(ovl_data));

    // Writable masks from R4 and R10
    function automatic logic [31:0] m_wm(int br, int i);
        if (i == 1) return 32'h0000_FFFF;
        if (i == 3) return 32'h0000_00FF;
        if (br == 0) return (i == 15) ? 32'h0000_00FF : 32'h0;
        case (i)
            6:  return 32'h00FF_FFFF;
            7:  return 32'hF900_0000;
            8, 9: return 32'hFFF0_FFF0;
            10, 11: return 32'hFFFF_FFFF;
            15: return 32'hFFFF_00FF;
            default: return 32'h0;
        endcase
    endfunction

    // Reset image from R1 with default identification values
    function automatic logic [31:0] m_rst(int br, int i);
        if (i == 0) return 32'h5678_1234;
        if (i == 2) return 32'h0401_0000;
        if (br == 0) return (i == 11) ? 32'h2468_ABCD : 32'h0;
        case (i)
            3: return 32'h0001_0000;
            7: return 32'h0000_00F0;
            8: return 32'h0000_FFF0;
            9: return 32'h0001_FFF1;
            default: return 32'h0;
        endcase
    endfunction

    function automatic void m_host(int idx, int off, int sz, logic [31:0] d);
        logic ok;
        logic [31:0] lm, m;
        ok = (idx < 64) && ((sz == 0) || (sz == 1 && (off % 2) == 0) || (sz == 2 && off == 0));
        if (!ok) return;
        lm = (sz == 0) ? (32'hFF << (8*off)) : (sz == 1) ? (32'hFFFF << (8*off)) : 32'hFFFF_FFFF;
        for (int b = 0; b < 2; b++) begin
            m = lm & m_wm(b, idx);
            ex[b][idx] = (ex[b][idx] & ~m) | ((d << (8*off)) & m);
        end
    endfunction

    function automatic void m_upd(int idx, logic [31:0] m, logic [31:0] d);
        for (int b = 0; b < 2; b++) ex[b][idx] = (ex[b][idx] & ~m) | (d & m);
    endfunction

    function automatic logic [31:0] m_rd(int br, int idx);
        return (idx < 64) ? ex[br][idx] : 32'hFFFF_FFFF;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_write(int idx, int off, int sz, logic [31:0] d);
        @(negedge clk);
        host_wr_en = 1'b1; host_idx = 7'(idx); host_off = 2'(off);
        host_size = 2'(sz); host_wdata = d;
        @(negedge clk);
        host_wr_en = 1'b0;
        m_host(idx, off, sz, d);
    endtask

    task automatic do_upd(int idx, logic [31:0] m, logic [31:0] d);
        @(negedge clk);
        upd_en = 1'b1; upd_idx = 6'(idx); upd_mask = m; upd_data = d;
        @(negedge clk);
        upd_en = 1'b0;
        m_upd(idx, m, d);
    endtask

    task automatic do_read(int idx, string req);
        @(negedge clk);
        host_rd_en = 1'b1; host_idx = 7'(idx);
        @(negedge clk);
        host_rd_en = 1'b0;
        chk({req, " endpoint"}, rdata_ep, m_rd(0, idx));
        chk({req, " bridge"}, rdata_br, m_rd(1, idx));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        logic [31:0] old0, old1;
        void'($urandom(32'h5EED));
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 64; i++) ex[b][i] = m_rst(b, i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        chk("R9 reset rdata", rdata_ep, 32'h0);
        // R1: whole reset image of both layouts
        for (int i = 0; i < 64; i++) do_read(i, "R1 reset image");

        // R4: identification dword is read-only
        do_write(0, 0, 2, 32'h0DF0_ADBA);
        do_read(0, "R4 dword0 read-only");
        do_write(2, 1, 0, 32'hFF);
        do_read(2, "R4 dword2 read-only");

        // R2: accepted merges at several sizes and offsets
        do_write(1, 0, 2, 32'hFFFF_FFFF);
        do_read(1, "R2 word write dword1");
        do_write(1, 1, 0, 32'h0000_0012);
        do_read(1, "R2 byte write offset1");
        do_write(15, 2, 1, 32'h0000_BEEF);
        do_read(15, "R10 half write dword15");
        do_write(7, 0, 2, 32'hFFFF_FFFF);
        do_read(7, "R10 bridge dword7 mask");
        do_write(10, 3, 0, 32'h0000_00C3);
        do_read(10, "R10 bridge dword10 byte3");

        // R3: dropped accesses
        do_write(3, 2, 2, 32'h0000_0077);
        do_read(3, "R3 misaligned word dropped");
        do_write(3, 1, 1, 32'h0000_7777);
        do_read(3, "R3 odd half dropped");
        do_write(3, 0, 3, 32'h0000_00AB);
        do_read(3, "R3 size code 3 dropped");
        do_write(3, 3, 0, 32'h0000_005A);
        do_read(3, "R3 byte any offset");

        // R5: out of range
        do_write(64, 0, 2, 32'h1234_5678);
        do_read(64, "R5 oob read");
        do_read(127, "R5 oob read top");
        do_read(0, "R5 oob write no alias");

        // R6: update ignores writable mask
        do_upd(0, 32'hFFFF_0000, 32'hCAFE_0000);
        do_read(0, "R6 update dword0");
        do_upd(2, 32'h0000_00FF, 32'h0000_0033);
        do_read(2, "R6 update dword2");

        // R7: same-cycle host write and update on one dword
        @(negedge clk);
        host_wr_en = 1'b1; host_idx = 7'd15; host_off = 2'd0; host_size = 2'd2;
        host_wdata = 32'h0000_00AA;
        upd_en = 1'b1; upd_idx = 6'd15; upd_mask = 32'h0000_000F; upd_data = 32'h0000_0005;
        @(negedge clk);
        host_wr_en = 1'b0; upd_en = 1'b0;
        m_host(15, 0, 2, 32'h0000_00AA);
        m_upd(15, 32'h0000_000F, 32'h0000_0005);
        do_read(15, "R7 update after host write");

        // R8: overlay on one dword only
        ovl_en = 1'b1; ovl_idx = 6'd11; ovl_mask = 32'hFF00_FF00; ovl_data = 32'h1234_5678;
        @(negedge clk);
        host_rd_en = 1'b1; host_idx = 7'd11;
        @(negedge clk);
        host_rd_en = 1'b0;
        chk("R8 overlay endpoint", rdata_ep, (ex[0][11] & 32'h00FF_00FF) | 32'h1200_5600);
        chk("R8 overlay bridge", rdata_br, (ex[1][11] & 32'h00FF_00FF) | 32'h1200_5600);
        do_read(1, "R8 overlay other dword");
        ovl_en = 1'b0;

        // R9: read in the same cycle as a write returns old contents, then holds
        old0 = ex[0][1]; old1 = ex[1][1];
        @(negedge clk);
        host_rd_en = 1'b1; host_wr_en = 1'b1; host_idx = 7'd1; host_off = 2'd0;
        host_size = 2'd2; host_wdata = 32'h0000_5A5A;
        @(negedge clk);
        host_rd_en = 1'b0; host_wr_en = 1'b0;
        m_host(1, 0, 2, 32'h0000_5A5A);
        chk("R9 read before write endpoint", rdata_ep, old0);
        chk("R9 read before write bridge", rdata_br, old1);
        do_upd(1, 32'hFFFF_FFFF, 32'h0F0F_0F0F);
        chk("R9 rdata hold", rdata_ep, old0);
        do_read(1, "R9 read after update");

        // Random mix of writes, updates and reads (R2, R3, R5, R6)
        for (int n = 0; n < 600; n++) begin
            int kind;
            kind = int'($urandom_range(0, 9));
            if (kind < 5)
                do_write(int'($urandom_range(0, 70)), int'($urandom_range(0, 3)),
                         int'($urandom_range(0, 3)), $urandom);
            else if (kind < 6)
                do_upd(int'($urandom_range(0, 63)), $urandom, $urandom);
            else
                do_read(int'($urandom_range(0, 70)), "R2 random read");
        end
        for (int i = 0; i < 64; i++) do_read(i, "R2 final sweep");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule